// File: doc/BRIEF.md
# Transmit Burst Copier: Word RAM to Transmit FIFO

This block belongs to the transmit side of a serial-bus remote terminal. A validated transmit command arrives as an active-low strobe of fixed width. While the strobe is low, the block takes the shared word RAM away from the host processor. The host is held off through an active-low acknowledge. A host cycle that was already granted when the strobe fell is given a short, fixed acknowledge pulse so that it can finish. When the strobe returns high, the block starts a burst. The burst copies 1 to 32 words from RAM into the transmit FIFO, one word per fixed pacing slot.

The burst cannot be interrupted. Host requests made during the strobe or the burst wait until the burst ends. After the last word, the RAM belongs to the host alone until the next strobe. The serializer then drains the FIFO without touching RAM again. If the FIFO reports full, the pending word is held and the pacing slot is frozen until the write can go through.

The lower bits of the command word carry two fields. The low `CNT_W` bits hold the word count. The next `SA_W` bits hold the subaddress, which selects a block of 2^CNT_W words in RAM.

Top module: `txdma_burst`

## Requirements
- R1: While reset is applied and in the cycle after it, `ram_rd_en` and `fifo_wr_en` are 0 and `host_ack_n` is 1.
- R2: No RAM read occurs while the strobe is low. The first read of a burst occurs in the cycle after the cycle in which `cmd_strobe_n` is first sampled high again.
- R3: Word i of a burst (i counting from 0) is read from address {cmd_word[SA_W+CNT_W-1:CNT_W], i}. The subaddress forms the upper address bits and i the lower CNT_W bits. The FIFO receives the words in ascending order, each with exactly the value RAM returned for its address one cycle after the read.
- R4: The word count is cmd_word[CNT_W-1:0], captured when the strobe rises; a value of 0 means 2^CNT_W (32) words. Exactly that many FIFO writes occur per burst.
- R5: Each word occupies a slot of WORD_CYC cycles. The read is in the first cycle of the slot and the FIFO write is two cycles after the read. When the FIFO is never full, reads are exactly WORD_CYC cycles apart.
- R6: While `fifo_full` is 1 in the write cycle of a slot, `fifo_wr_en` stays 0, `fifo_wdata` holds, and the slot timer does not advance. Each stalled cycle therefore delays every later read by one cycle.
- R7: With no strobe and no burst, `host_ack_n` falls one cycle after `host_req` rises and returns high one cycle after it falls.
- R8: If `host_ack_n` is low when the falling strobe is sampled, it stays low for ACK_HOLD_CYC cycles counted from that edge and then goes high. If it is high at that edge, it stays high.
- R9: Apart from the R8 pulse, `host_ack_n` is 1 throughout the strobe and the burst. A pending request is granted on the clock edge that ends the last slot, so `host_ack_n` is low in the first cycle after the burst.
- R10: Asserting `host_req` before or during a burst does not shorten, pause or reorder it; the burst still makes its full count of writes.
- R11: After a burst completes, no RAM read occurs until the next strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_strobe_n | input | 1 | Active-low validated transmit command strobe |
| cmd_word | input | SA_W+CNT_W | Subaddress (upper) and word count (lower) fields of the command |
| host_req | input | 1 | Host asks for the RAM |
| host_ack_n | output | 1 | Active-low grant of the RAM to the host |
| ram_rd_en | output | 1 | RAM read strobe, data returned next cycle |
| ram_addr | output | SA_W+CNT_W | RAM word address |
| ram_rdata | input | DATA_W | RAM read data |
| fifo_wr_en | output | 1 | Push one word into the transmit FIFO |
| fifo_wdata | output | DATA_W | Word pushed into the FIFO |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |

## Verification
The copy path is tried with short counts, with a count field of zero (the full 32-word burst at the top subaddress), and with one-word and mid-length bursts under a pseudo-random full pattern. Comparing these separates a wrong count decode from a wrong address composition, and a frozen slot timer from one that keeps running through a stall. The arbitration is tried three ways: with the host granted as the strobe falls, with the host requesting in the middle of a burst, and with the host idle. This separates the finishing pulse from the ordinary hold-off, and shows whether the grant arrives on the completion edge rather than a cycle later. RAM data depends on the address in an invertible way, so any skipped, repeated or reordered word shows up as a data mismatch.

// File: rtl/txdma_pkg.sv
// Shared types for the transmit burst copier.
// Assumes: nothing beyond the types declared here.
package txdma_pkg;

    // Control sequence of the copier: idle, strobe window, burst in progress.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MOVE = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/txdma_strobe_edge.sv
// Samples the active-low command strobe and reports its edges.
// Assumes: the strobe is already synchronous to clk; the register resets to
// the inactive (high) level, so a strobe held low out of reset shows a fall.
module txdma_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall,
    output logic rise
);

    logic strobe_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
        end else begin
            strobe_q <= strobe_n;
        end
    end

    // Edge pulses, valid in the cycle the new level is seen.
    always_comb begin
        fall = strobe_q & ~strobe_n;
        rise = ~strobe_q & strobe_n;
    end

endmodule

// File: rtl/txdma_host_arb.sv
// Grants the shared RAM to the host through an active-low acknowledge.
// When idle, the acknowledge follows the request with one cycle of delay.
// A falling strobe that finds the host granted keeps the grant for
// HOLD_CYC cycles so that the host's cycle can finish; otherwise the host is
// held off until the burst ends. On the edge that ends the burst, a pending
// request is granted.
// Assumes: HOLD_CYC >= 1 and the strobe is low for longer than HOLD_CYC
// cycles, so the finishing pulse ends before the first burst read.
module txdma_host_arb #(
    parameter int HOLD_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic idle,
    input  logic strobe_fall,
    input  logic burst_done,
    output logic host_ack_n
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hold_q;
    logic          ack_n_q;
    logic          take_fall;
    logic          idle_next;

    // A fall is acted on only from idle; later edges belong to the burst.
    always_comb begin
        take_fall = strobe_fall & idle;
        idle_next = (idle & ~strobe_fall) | burst_done;
    end

    // Acknowledge register and finishing-pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_n_q <= 1'b1;
            hold_q  <= '0;
        end else if (take_fall) begin
            hold_q  <= ack_n_q ? '0 : HOLD_LOAD;
            ack_n_q <= ack_n_q;
        end else if (hold_q != '0) begin
            hold_q  <= hold_q - HW'(1);
            ack_n_q <= 1'b0;
        end else if (idle_next) begin
            ack_n_q <= ~host_req;
        end else begin
            ack_n_q <= 1'b1;
        end
    end

    assign host_ack_n = ack_n_q;

endmodule

// File: rtl/txdma_mover.sv
// Paced word copier. Each word uses a slot of WORD_CYC cycles:
// phase 0 issues the RAM read, phase 1 captures the returned word,
// phase 2 pushes it into the FIFO (held while the FIFO is full, with the
// phase counter frozen), and the remaining phases are idle spacing.
// Assumes: WORD_CYC >= 3, RAM read latency of exactly one cycle,
// 1 <= len <= 2**CNT_W when start is pulsed.
module txdma_mover #(
    parameter int DATA_W   = 16,
    parameter int SA_W     = 5,
    parameter int CNT_W    = 5,
    parameter int WORD_CYC = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [SA_W-1:0]         sa,
    input  logic [CNT_W:0]          len,
    output logic                    ram_rd_en,
    output logic [SA_W+CNT_W-1:0]   ram_addr,
    input  logic [DATA_W-1:0]       ram_rdata,
    output logic                    fifo_wr_en,
    output logic [DATA_W-1:0]       fifo_wdata,
    input  logic                    fifo_full,
    output logic                    busy,
    output logic                    stall,
    output logic                    done
);

    localparam int PH_W = $clog2(WORD_CYC);
    localparam logic [PH_W-1:0] PH_RD   = PH_W'(0);
    localparam logic [PH_W-1:0] PH_CAP  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_WR   = PH_W'(2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_CYC - 1);

    logic              busy_q;
    logic [PH_W-1:0]   ph_q;
    logic [CNT_W:0]    idx_q;
    logic [CNT_W:0]    len_q;
    logic [SA_W-1:0]   sa_q;
    logic [DATA_W-1:0] word_q;
    logic              slot_end;
    logic              last_word;

    // Slot decode: read, write, stall and end-of-slot conditions.
    always_comb begin
        stall      = busy_q && (ph_q == PH_WR) && fifo_full;
        slot_end   = busy_q && (ph_q == PH_LAST) && !stall;
        last_word  = (idx_q + (CNT_W + 1)'(1)) == len_q;
        done       = slot_end && last_word;
        ram_rd_en  = busy_q && (ph_q == PH_RD);
        fifo_wr_en = busy_q && (ph_q == PH_WR) && !fifo_full;
        ram_addr   = {sa_q, idx_q[CNT_W-1:0]};
        fifo_wdata = word_q;
        busy       = busy_q;
    end

    // Burst sequencing: slot phase, word index and captured parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            sa_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            ph_q   <= PH_RD;
            idx_q  <= '0;
            len_q  <= len;
            sa_q   <= sa;
        end else if (busy_q && !stall) begin
            if (slot_end) begin
                ph_q <= PH_RD;
                if (last_word) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + (CNT_W + 1)'(1);
                end
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end
    end

    // Word holding register, loaded one cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (busy_q && (ph_q == PH_CAP)) begin
            word_q <= ram_rdata;
        end
    end

endmodule

// File: rtl/txdma_burst.sv
// Top of the transmit burst copier. Sequences idle -> strobe window ->
// burst -> idle, decodes the command fields, and connects the strobe edge
// detector, the host arbiter and the paced mover.
// Assumes: cmd_word is stable when the strobe rises; a strobe that falls
// during a burst is ignored.
module txdma_burst #(
    parameter int DATA_W       = 16,
    parameter int SA_W         = 5,
    parameter int CNT_W        = 5,
    parameter int WORD_CYC     = 100,
    parameter int ACK_HOLD_CYC = 50
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_strobe_n,
    input  logic [SA_W+CNT_W-1:0] cmd_word,
    input  logic                  host_req,
    output logic                  host_ack_n,
    output logic                  ram_rd_en,
    output logic [SA_W+CNT_W-1:0] ram_addr,
    input  logic [DATA_W-1:0]     ram_rdata,
    output logic                  fifo_wr_en,
    output logic [DATA_W-1:0]     fifo_wdata,
    input  logic                  fifo_full
);

    import txdma_pkg::*;

    localparam int FIELD_W = SA_W + CNT_W;

    ctl_state_t       st_q;
    logic             strb_fall;
    logic             strb_rise;
    logic             mv_start;
    logic             mv_busy;
    logic             mv_stall;
    logic             mv_done;
    logic             in_idle;
    logic             in_wait;
    logic [CNT_W-1:0] cnt_field;
    logic [SA_W-1:0]  sa_field;
    logic [CNT_W:0]   len_dec;

    // Field split and count decode (zero count means the maximum).
    always_comb begin
        cnt_field = cmd_word[CNT_W-1:0];
        sa_field  = cmd_word[FIELD_W-1:CNT_W];
        len_dec   = (cnt_field == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_field};
        in_idle   = (st_q == ST_IDLE);
        in_wait   = (st_q == ST_WAIT);
        mv_start  = in_wait && strb_rise;
    end

    // Control sequence: leave idle on the fall, burst on the rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (strb_fall) st_q <= ST_WAIT;
                ST_WAIT: if (strb_rise) st_q <= ST_MOVE;
                ST_MOVE: if (mv_done)   st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    txdma_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (cmd_strobe_n),
        .fall     (strb_fall),
        .rise     (strb_rise)
    );

    txdma_host_arb #(
        .HOLD_CYC (ACK_HOLD_CYC)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .idle        (in_idle),
        .strobe_fall (strb_fall),
        .burst_done  (mv_done),
        .host_ack_n  (host_ack_n)
    );

    txdma_mover #(
        .DATA_W   (DATA_W),
        .SA_W     (SA_W),
        .CNT_W    (CNT_W),
        .WORD_CYC (WORD_CYC)
    ) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (mv_start),
        .sa         (sa_field),
        .len        (len_dec),
        .ram_rd_en  (ram_rd_en),
        .ram_addr   (ram_addr),
        .ram_rdata  (ram_rdata),
        .fifo_wr_en (fifo_wr_en),
        .fifo_wdata (fifo_wdata),
        .fifo_full  (fifo_full),
        .busy       (mv_busy),
        .stall      (mv_stall),
        .done       (mv_done)
    );

endmodule

// File: rtl/txdma_checker.sv
// Temporal checks for the transmit burst copier, bound to its top.
// Assumes: the strobe stays low longer than the acknowledge hold pulse.
module txdma_checker #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_rd_en,
    input logic              fifo_wr_en,
    input logic              fifo_full,
    input logic [DATA_W-1:0] fifo_wdata,
    input logic              host_ack_n,
    input logic              in_wait,
    input logic              mv_busy,
    input logic              mv_stall,
    input logic              mv_start
);

    localparam int MAXW = 1 << CNT_W;

    logic [CNT_W+1:0] wr_cnt;

    // Count FIFO writes since the latest burst start.
    always_ff @(posedge clk) begin
        if (!rst_n || mv_start) begin
            wr_cnt <= '0;
        end else if (fifo_wr_en) begin
            wr_cnt <= wr_cnt + (CNT_W + 2)'(1);
        end
    end

    assert_no_read_in_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> !ram_rd_en);

    assert_read_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> !ram_rd_en);

    assert_full_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr_en);

    assert_stall_holds_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mv_stall |=> $stable(fifo_wdata));

    assert_host_off_during_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> host_ack_n);

    assert_no_read_outside_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_busy |-> !ram_rd_en);

    assert_word_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= (CNT_W + 2)'(MAXW));

endmodule

bind txdma_burst txdma_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_rd_en  (ram_rd_en),
    .fifo_wr_en (fifo_wr_en),
    .fifo_full  (fifo_full),
    .fifo_wdata (fifo_wdata),
    .host_ack_n (host_ack_n),
    .in_wait    (in_wait),
    .mv_busy    (mv_busy),
    .mv_stall   (mv_stall),
    .mv_start   (mv_start)
);

// File: tb/tb_txdma_burst.sv
module tb_txdma_burst;

    localparam int DATA_W   = 16;
    localparam int SA_W     = 5;
    localparam int CNT_W    = 5;
    localparam int AW       = SA_W + CNT_W;
    localparam int WORD_CYC = 5;
    localparam int HOLD     = 4;
    localparam int STRB_CYC = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_strobe_n = 1'b1;
    logic [AW-1:0]     cmd_word = '0;
    logic              host_req = 1'b0;
    logic              host_ack_n;
    logic              ram_rd_en;
    logic [AW-1:0]     ram_addr;
    logic [DATA_W-1:0] ram_rdata = '0;
    logic              fifo_wr_en;
    logic [DATA_W-1:0] fifo_wdata;
    logic              fifo_full = 1'b0;

    int checks = 0;
    int fails  = 0;
    int wr_seen = 0;
    bit stall_en = 1'b0;
    bit run_done = 1'b0;

    always #5 clk = ~clk;

    txdma_burst #(
        .DATA_W (DATA_W), .SA_W (SA_W), .CNT_W (CNT_W),
        .WORD_CYC (WORD_CYC), .ACK_HOLD_CYC (HOLD)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cmd_strobe_n (cmd_strobe_n),
        .cmd_word (cmd_word), .host_req (host_req), .host_ack_n (host_ack_n),
        .ram_rd_en (ram_rd_en), .ram_addr (ram_addr), .ram_rdata (ram_rdata),
        .fifo_wr_en (fifo_wr_en), .fifo_wdata (fifo_wdata), .fifo_full (fifo_full)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Invertible address-to-data map for the RAM model.
    function automatic logic [DATA_W-1:0] ram_f(input logic [AW-1:0] a);
        return 16'hC3A5 ^ {a, 6'h00} ^ 16'(a);
    endfunction

    // RAM model: one cycle read latency.
    always @(posedge clk) if (ram_rd_en) ram_rdata <= ram_f(ram_addr);

    // FIFO full pattern source.
    initial begin
        logic [7:0] x = 8'h5B;
        forever begin
            @(posedge clk); #2;
            x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
            fifo_full = stall_en ? x[0] : 1'b0;
        end
    end

    // Reference model, advanced on each rising edge.
    int m_mode, m_age, m_idx, m_total, m_base, m_hold;
    bit m_ack, m_sprev;
    logic [DATA_W-1:0] m_q[$];

    always @(posedge clk) begin
        bit fall, rise, stall, finish;
        if (!rst_n) begin
            m_mode = 0; m_age = 0; m_idx = 0; m_total = 0; m_base = 0;
            m_hold = 0; m_ack = 1'b1; m_sprev = 1'b1;
        end else begin
            fall   = m_sprev && !cmd_strobe_n;
            rise   = !m_sprev && cmd_strobe_n;
            stall  = (m_mode == 2) && (m_age == 2) && fifo_full;
            finish = (m_mode == 2) && !stall && (m_age == WORD_CYC - 1) && (m_idx == m_total - 1);
            if (m_mode == 2 && m_age == 0) m_q.push_back(ram_f(AW'(m_base + m_idx)));
            if (fall && m_mode == 0) begin
                if (!m_ack) m_hold = HOLD - 1;
            end else if (m_hold != 0) begin
                m_hold--; m_ack = 1'b0;
            end else if (m_mode == 0 || finish) begin
                m_ack = !host_req;
            end else begin
                m_ack = 1'b1;
            end
            if (m_mode == 0) begin
                if (fall) m_mode = 1;
            end else if (m_mode == 1) begin
                if (rise) begin
                    m_mode  = 2;
                    m_total = (cmd_word[CNT_W-1:0] == 0) ? 32 : int'(cmd_word[CNT_W-1:0]);
                    m_base  = int'(cmd_word[AW-1:CNT_W]) * 32;
                    m_idx = 0; m_age = 0;
                end
            end else if (!stall) begin
                if (m_age == WORD_CYC - 1) begin
                    if (finish) m_mode = 0;
                    else begin m_idx++; m_age = 0; end
                end else begin
                    m_age++;
                end
            end
            m_sprev = cmd_strobe_n;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !run_done) begin
            bit exp_rd, exp_wr;
            logic [DATA_W-1:0] e;
            exp_rd = (m_mode == 2) && (m_age == 0);
            exp_wr = (m_mode == 2) && (m_age == 2) && !fifo_full;
            check(ram_rd_en == exp_rd, "R5 read slot timing", ram_rd_en, exp_rd);
            if (exp_rd && ram_rd_en)
                check(ram_addr == AW'(m_base + m_idx), "R3 read address", ram_addr, m_base + m_idx);
            check(fifo_wr_en == exp_wr, "R6 write or stall timing", fifo_wr_en, exp_wr);
            if (fifo_wr_en) begin
                wr_seen++;
                if (m_q.size() == 0) check(1'b0, "R3 unexpected write", fifo_wdata, 0);
                else begin
                    e = m_q.pop_front();
                    check(fifo_wdata == e, "R3 word order and value", fifo_wdata, e);
                end
            end
            check(host_ack_n == m_ack, "R9 acknowledge sequence", host_ack_n, m_ack);
        end
    end

    // One transmit command: strobe window, burst, completion checks.
    task automatic run_burst(input int sa, input int cnt, input int hold_exp, input bit req_mid);
        int ack_low = 0;
        int rd_low = 0;
        int base_wr;
        int exp_len;
        int idle_rd = 0;
        exp_len = (cnt == 0) ? 32 : cnt;
        cmd_word = {SA_W'(sa), CNT_W'(cnt)};
        base_wr = wr_seen;
        @(posedge clk); #2 cmd_strobe_n = 1'b0;
        for (int i = 0; i < STRB_CYC - 1; i++) begin
            @(negedge clk);
            if (!host_ack_n) ack_low++;
            if (ram_rd_en) rd_low++;
        end
        check(ack_low == hold_exp, "R8 finishing pulse length", ack_low, hold_exp);
        check(rd_low == 0, "R2 no read while strobe low", rd_low, 0);
        @(posedge clk); #2 cmd_strobe_n = 1'b1;
        @(negedge clk);
        check(ram_rd_en == 1'b0, "R2 no read before rise sampled", ram_rd_en, 0);
        @(negedge clk);
        check(ram_rd_en == 1'b1, "R2 first read after rise", ram_rd_en, 1);
        if (req_mid) begin
            @(posedge clk); #2 host_req = 1'b1;
            @(negedge clk); @(negedge clk);
            check(host_ack_n == 1'b1, "R9 request held off in burst", host_ack_n, 1);
        end
        while (m_mode != 0) @(negedge clk);
        check(wr_seen - base_wr == exp_len, "R4 words per burst", wr_seen - base_wr, exp_len);
        if (host_req) begin
            check(host_ack_n == 1'b0, "R9 grant right after burst", host_ack_n, 0);
            check(wr_seen - base_wr == exp_len, "R10 request did not cut burst", wr_seen - base_wr, exp_len);
        end
        for (int i = 0; i < 3 * WORD_CYC; i++) begin
            @(negedge clk);
            if (ram_rd_en) idle_rd++;
        end
        check(idle_rd == 0, "R11 no read after burst", idle_rd, 0);
        @(posedge clk); #2 host_req = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ram_rd_en == 1'b0, "R1 reset read", ram_rd_en, 0);
        check(fifo_wr_en == 1'b0, "R1 reset write", fifo_wr_en, 0);
        check(host_ack_n == 1'b1, "R1 reset acknowledge", host_ack_n, 1);
        @(posedge clk); #2 rst_n = 1'b1;
        @(negedge clk);
        check(host_ack_n == 1'b1, "R1 acknowledge after reset", host_ack_n, 1);

        // R7: idle grant and release
        @(posedge clk); #2 host_req = 1'b1;
        @(negedge clk);
        check(host_ack_n == 1'b1, "R7 no grant same cycle", host_ack_n, 1);
        @(negedge clk);
        check(host_ack_n == 1'b0, "R7 grant one cycle later", host_ack_n, 0);
        @(posedge clk); #2 host_req = 1'b0;
        @(negedge clk); @(negedge clk);
        check(host_ack_n == 1'b1, "R7 release", host_ack_n, 1);

        run_burst(2, 3, 0, 1'b0);
        run_burst(31, 0, 0, 1'b0);

        // R8/R10: host granted when the strobe falls, request kept up
        @(posedge clk); #2 host_req = 1'b1;
        repeat (3) @(posedge clk);
        run_burst(7, 5, HOLD + 1, 1'b0);

        run_burst(1, 4, 0, 1'b1);

        // R6: FIFO full stalls
        stall_en = 1'b1;
        run_burst(20, 7, 0, 1'b0);
        run_burst(9, 1, 0, 1'b0);
        stall_en = 1'b0;

        run_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule